// File: doc/BRIEF.md
# Serial Command and Status Port for a Display Controller

This block is the slave-side front end of a display controller's serial host link. A host selects the block with an active-low select, clocks bytes in on a shared serial data line, most significant bit first, and marks each byte as a command or as display data with a separate select line. Each completed byte appears on a parallel output together with a single-cycle strobe and a command flag. These signals are in the system clock domain, so the controller core behind the port can use them without crossing clocks.

All four host inputs are brought into the system clock domain through two-flop synchronisers. The serial clock edges are then detected there. When the host sends the status-read command, the block turns the shared data line around and becomes its driver. It shifts a captured status byte back out on the following serial clocks, and repeats it every eight clocks, until the select is released. Releasing the select at any time discards a partial byte, clears the bit counter and returns the line to input.

Top module: `lcd_serial_port`

## Requirements
- R1: After reset, `byte_valid_o` and `sdo_oe_o` are 0.
- R2: With `cs_ni` low, eight rising edges of `sclk_i` form one byte. The bit sampled on the first edge becomes `byte_o[7]` and the bit sampled on the eighth edge becomes `byte_o[0]`.
- R3: `byte_is_cmd_o` is 1 when `dc_i` was 0 at the eighth rising edge (command), and 0 when `dc_i` was 1 (display data).
- R4: `byte_valid_o` is high for exactly one system clock cycle per received byte.
- R5: Raising `cs_ni` discards a partially shifted byte. The next byte after select goes low again starts with its most significant bit.
- R6: While `cs_ni` is high, activity on `sclk_i`, `sdi_i` and `dc_i` produces no strobe and does not drive the data line.
- R7: While `cs_ni` stays low, bytes can follow one another without gaps. The bit counter wraps after every eighth bit.
- R8: A command byte equal to parameter `RD_OPCODE` (default 8'hD0) puts the block in read mode and sets `sdo_oe_o` to 1. `sdo_o` presents status bit 7 at once and advances one bit after each falling `sclk_i` edge that follows a rising edge in read mode.
- R9: The status byte is taken from `status_i` when read mode begins. The same captured byte is sent again every eight clocks, even if `status_i` changes later.
- R10: A data byte (`dc_i` = 1) equal to `RD_OPCODE` is delivered as data and does not start read mode.
- R11: Raising `cs_ni` ends read mode, and `sdo_oe_o` returns to 0.
- R12: In read mode no byte strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data line, input side |
| dc_i | input | 1 | Byte kind: 0 command, 1 display data |
| status_i | input | 8 | Status byte offered for read-back |
| byte_o | output | 8 | Last received byte |
| byte_valid_o | output | 1 | One-cycle strobe for a new byte |
| byte_is_cmd_o | output | 1 | Received byte was a command |
| sdo_o | output | 1 | Serial data line, output side |
| sdo_oe_o | output | 1 | Drive enable for the serial data line |

## Verification
A wrong bit count shows up as a shifted byte on `byte_o`, or as a missing strobe, at the very next byte boundary. A count left over from an aborted transfer corrupts the first byte after the select is reasserted. A read-mode flag that is wrong shows up on `sdo_oe_o` within three system clocks of the eighth serial edge or of the select's release. A slip in the transmit shift shows up as a wrong `sdo_o` level one serial bit later. The bench runs a behavioural model and compares the strobe, data, flag, enable and line level against it on every clock. It also reads the status back bit by bit the way a host would.

// File: rtl/lcd_sp_pkg.sv
package lcd_sp_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  // host pins in the order they are synchronised
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic sdi;
    logic dc;
  } host_pins_t;

  localparam int PINS_W = $bits(host_pins_t);
endpackage

// File: rtl/lcd_sp_sync.sv
module lcd_sp_sync #(
  parameter int            W       = 4,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
      end
    end
    assign q_o[g] = stab_q;
  end
endmodule

// File: rtl/lcd_sp_rx.sv
module lcd_sp_rx
  import lcd_sp_pkg::*;
#(
  parameter byte_t RD_OPCODE = 8'hD0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_act_i,
  input  logic  rise_i,
  input  logic  sdi_i,
  input  logic  dc_i,
  input  logic  rd_mode_i,
  output byte_t byte_o,
  output logic  valid_o,
  output logic  is_cmd_o,
  output logic  rd_start_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  byte_t            sh_q, sh_d, byte_q, byte_d;
  logic             valid_q, valid_d, cmd_q, cmd_d;
  byte_t            shifted;
  logic             take, last, done;

  assign shifted    = {sh_q[BYTE_W-2:0], sdi_i};
  assign take       = cs_act_i & ~rd_mode_i & rise_i;
  assign last       = (cnt_q == CNT_W'(BYTE_W - 1));
  assign done       = take & last;
  assign rd_start_o = done & ~dc_i & (shifted == RD_OPCODE);

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    byte_d  = byte_q;
    cmd_d   = cmd_q;
    valid_d = done;
    if (!cs_act_i) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (take) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
      sh_d  = shifted;
    end
    if (done) begin
      byte_d = shifted;
      cmd_d  = ~dc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
      cmd_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      byte_q  <= byte_d;
      valid_q <= valid_d;
      cmd_q   <= cmd_d;
    end
  end

  assign byte_o   = byte_q;
  assign valid_o  = valid_q;
  assign is_cmd_o = cmd_q;

  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_partial_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (cnt_q == '0));
  assert_idle_no_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !valid_q);
endmodule

// File: rtl/lcd_sp_tx.sv
module lcd_sp_tx
  import lcd_sp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_act_i,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  rd_start_i,
  input  byte_t status_i,
  output logic  sdo_o,
  output logic  rd_mode_o
);
  logic             rd_q, rd_d, pend_q, pend_d;
  byte_t            tx_q, tx_d, stat_q, stat_d;
  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic             shift;

  assign shift = rd_q & fall_i & pend_q;

  always_comb begin
    rd_d   = cs_act_i & (rd_q | rd_start_i);
    tx_d   = tx_q;
    stat_d = stat_q;
    tcnt_d = tcnt_q;
    pend_d = pend_q;
    if (!cs_act_i) begin
      tcnt_d = '0;
      pend_d = 1'b0;
    end else if (rd_start_i) begin
      tx_d   = status_i;
      stat_d = status_i;
      tcnt_d = '0;
      pend_d = 1'b0;
    end else if (rd_q) begin
      if (rise_i) begin
        pend_d = 1'b1;
      end else if (shift) begin
        pend_d = 1'b0;
        if (tcnt_q == CNT_W'(BYTE_W - 1)) begin
          tx_d   = stat_q;
          tcnt_d = '0;
        end else begin
          tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
          tcnt_d = tcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      tx_q   <= '0;
      stat_q <= '0;
      tcnt_q <= '0;
      pend_q <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      tx_q   <= tx_d;
      stat_q <= stat_d;
      tcnt_q <= tcnt_d;
      pend_q <= pend_d;
    end
  end

  assign sdo_o     = tx_q[BYTE_W-1] & rd_q;
  assign rd_mode_o = rd_q;

  assert_line_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q && !fall_i) |=> $stable(tx_q));
  assert_release_ends_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !rd_q);
endmodule

// File: rtl/lcd_serial_port.sv
module lcd_serial_port
  import lcd_sp_pkg::*;
#(
  parameter byte_t RD_OPCODE = 8'hD0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sclk_i,
  input  logic       sdi_i,
  input  logic       dc_i,
  input  logic [7:0] status_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       byte_is_cmd_o,
  output logic       sdo_o,
  output logic       sdo_oe_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  host_pins_t pins_raw, pins_s;
  logic       sclk_prev_q;
  logic       cs_act, rise, fall, rd_mode, rd_start;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  assign pins_raw = '{cs_n: cs_ni, sclk: sclk_i, sdi: sdi_i, dc: dc_i};

  lcd_sp_sync #(.W(PINS_W), .RST_VAL(PINS_W'(4'b1000))) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= pins_s.sclk;
  end

  assign cs_act = ~pins_s.cs_n;
  assign rise   = pins_s.sclk & ~sclk_prev_q;
  assign fall   = ~pins_s.sclk & sclk_prev_q;

  lcd_sp_rx #(.RD_OPCODE(RD_OPCODE)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .cs_act_i  (cs_act),
    .rise_i    (rise),
    .sdi_i     (pins_s.sdi),
    .dc_i      (pins_s.dc),
    .rd_mode_i (rd_mode),
    .byte_o    (byte_o),
    .valid_o   (byte_valid_o),
    .is_cmd_o  (byte_is_cmd_o),
    .rd_start_o(rd_start)
  );

  lcd_sp_tx u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .cs_act_i  (cs_act),
    .rise_i    (rise),
    .fall_i    (fall),
    .rd_start_i(rd_start),
    .status_i  (status_i),
    .sdo_o     (sdo_o),
    .rd_mode_o (rd_mode)
  );

  assign sdo_oe_o = rd_mode;

  assert_read_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_mode && $past(rd_mode)) |-> !byte_valid_o);
  assert_enable_from_command_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> (byte_valid_o && byte_is_cmd_o && byte_o == RD_OPCODE));
endmodule

// File: tb/lcd_serial_port_tb_top.sv
module lcd_serial_port_tb_top;
  localparam logic [7:0] OPC = 8'hD0;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, dc = 1'b0;
  logic [7:0] status = 8'h00;
  logic [7:0] byte_o;
  logic byte_valid, byte_cmd, sdo, sdo_oe;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  lcd_serial_port #(.RD_OPCODE(OPC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .dc_i(dc), .status_i(status), .byte_o(byte_o), .byte_valid_o(byte_valid),
    .byte_is_cmd_o(byte_cmd), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: pin history, bits gathered in an int
  logic [3:0] hist[$];
  int  m_bits, m_nbits, m_tbit, m_tcount;
  bit  m_valid, m_cmd, m_rd, m_armed, m_run;
  logic [7:0] m_data, m_stat;

  always @(posedge clk) begin
    logic [3:0] now2, now3;
    bit act, up, down;
    hist.push_front({cs_n, sclk, sdi, dc});
    if (hist.size() > 4) void'(hist.pop_back());
    if (!rst_n) begin
      m_bits = 0; m_nbits = 0; m_valid = 0; m_rd = 0; m_armed = 0; m_tcount = 0;
      m_tbit = 7; m_stat = 0; m_data = 0; m_cmd = 0;
    end else begin
      now2 = hist[2]; now3 = hist[3];
      act  = !now2[3];
      up   = now2[2] && !now3[2];
      down = !now2[2] && now3[2];
      m_valid = 0;
      if (!act) begin
        m_bits = 0; m_nbits = 0; m_rd = 0; m_armed = 0; m_tcount = 0;
      end else if (m_rd) begin
        if (up) m_armed = 1;
        else if (down && m_armed) begin
          m_armed = 0;
          m_tcount++;
          m_tbit = 7 - (m_tcount % 8);
        end
      end else if (up) begin
        m_bits = ((m_bits * 2) + int'(now2[1])) % 256;
        m_nbits++;
        if (m_nbits == 8) begin
          m_valid = 1; m_data = m_bits[7:0]; m_cmd = !now2[0]; m_nbits = 0;
          if (m_cmd && m_data == OPC) begin
            m_rd = 1; m_stat = status; m_tcount = 0; m_tbit = 7; m_armed = 0;
          end
        end
      end
    end
  end

  logic [8:0] rxq[$];
  always @(negedge clk) begin
    if (rst_n && m_run) begin
      chk(byte_valid == m_valid, "R4 strobe", {7'd0, byte_valid}, {7'd0, m_valid});
      chk(sdo_oe == m_rd, "R11 enable", {7'd0, sdo_oe}, {7'd0, m_rd});
      if (m_valid) begin
        chk(byte_o == m_data, "R2 data", byte_o, m_data);
        chk(byte_cmd == m_cmd, "R3 kind", {7'd0, byte_cmd}, {7'd0, m_cmd});
      end
      if (m_rd) chk(sdo == m_stat[m_tbit], "R8 line", {7'd0, sdo}, {7'd0, m_stat[m_tbit]});
    end
    if (rst_n && byte_valid) rxq.push_back({byte_cmd, byte_o});
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel(input bit low);
    cs_n = !low;
    wait_clk(6);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit is_data);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i]; dc = is_data;
      wait_clk(HALF); sclk = 1'b1;
      wait_clk(HALF); sclk = 1'b0;
    end
  endtask

  task automatic read_byte(input logic [7:0] exp, input string req);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(HALF);
      chk(sdo === exp[i] && sdo_oe === 1'b1, req, {7'd0, sdo}, {7'd0, exp[i]});
      sclk = 1'b1;
      wait_clk(HALF); sclk = 1'b0;
    end
  endtask

  task automatic expect_rx(input bit cmd, input logic [7:0] d, input string req);
    logic [8:0] got;
    wait_clk(4);
    if (rxq.size() == 0) begin
      chk(0, req, 8'h00, d);
    end else begin
      got = rxq.pop_front();
      chk(got == {cmd, d}, req, got[7:0], d);
    end
  endtask

  task automatic expect_none(input string req);
    wait_clk(4);
    chk(rxq.size() == 0, req, 8'(rxq.size()), 8'd0);
    rxq.delete();
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    chk(byte_valid == 1'b0, "R1 strobe after reset", {7'd0, byte_valid}, 8'd0);
    chk(sdo_oe == 1'b0, "R1 enable after reset", {7'd0, sdo_oe}, 8'd0);
    m_run = 1;

    // R2 R3 R7: back-to-back data and command bytes
    sel(1);
    send_byte(8'hA5, 1); send_byte(8'h3C, 0); send_byte(8'h01, 1);
    expect_rx(0, 8'hA5, "R2 msb-first data");
    expect_rx(1, 8'h3C, "R3 command flag");
    expect_rx(0, 8'h01, "R7 third byte without gap");
    sel(0);

    // R5: partial byte discarded
    sel(1);
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    sel(0); sel(1);
    send_byte(8'h5A, 1);
    expect_rx(0, 8'h5A, "R5 realigned after release");
    expect_none("R5 no stray byte");
    sel(0);

    // R6: activity while deselected
    for (int i = 0; i < 20; i++) begin
      sdi = i[0]; dc = i[1]; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    expect_none("R6 ignored while deselected");
    chk(sdo_oe == 1'b0, "R6 line not driven", {7'd0, sdo_oe}, 8'd0);

    // R10: opcode as data
    sel(1);
    send_byte(OPC, 1);
    expect_rx(0, OPC, "R10 opcode as data delivered");
    chk(sdo_oe == 1'b0, "R10 no read mode", {7'd0, sdo_oe}, 8'd0);
    sel(0);

    // R8 R9 R12: status read, repeated byte, status changes later
    status = 8'hB6;
    sel(1);
    send_byte(OPC, 0);
    expect_rx(1, OPC, "R8 opcode delivered as command");
    status = 8'h49;
    read_byte(8'hB6, "R8 status bits");
    read_byte(8'hB6, "R9 captured status repeats");
    expect_none("R12 no strobe in read");
    sel(0);
    chk(sdo_oe == 1'b0, "R11 release ends read", {7'd0, sdo_oe}, 8'd0);

    // R11: abort mid-read, then a normal write
    status = 8'h0F;
    sel(1);
    send_byte(OPC, 0);
    expect_rx(1, OPC, "R8 second entry");
    for (int i = 0; i < 3; i++) begin
      wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    sel(0);
    chk(sdo_oe == 1'b0, "R11 abort mid-byte", {7'd0, sdo_oe}, 8'd0);
    sel(1);
    send_byte(8'hC3, 0);
    expect_rx(1, 8'hC3, "R11 write after read");
    sel(0);
    wait_clk(10);
    finish_run();
  end
endmodule